// File: doc/BRIEF.md
# Return Target Predictor with Pointer Recovery

This block predicts where a procedure return will go. When the front end sees a call, it hands the block the call's own address. The block stores the address of the next sequential instruction, which is the call address plus 4, on a small circular stack. When a return is seen, the block pops the top entry, and that entry is the predicted next fetch address. The prediction is always visible on `tgt_o`. `tgt_valid_o` tells whether the stack holds a live entry at all.

The front end keeps fetching down predicted paths, so calls and returns on a wrong path move the stack pointer as well. To undo this, the block can save its top pointer and its occupancy count under a small tag when a conditional branch is predicted. If that branch later turns out to be mispredicted, the block reloads both from the tagged save. Only the pointer state is saved and reloaded. Entries that a wrong-path call overwrote stay overwritten.

The storage wraps when it fills. A push on a full stack overwrites the oldest entry, so very deep call chains will later give wrong targets.

Top module: `retstack_top`

## Requirements
- R1: A cycle with `call_i` high and `ret_i` low stores `call_pc_i + 4` as the new top. From the next cycle, `tgt_o` shows that value and `tgt_valid_o` is 1.
- R2: A cycle with `ret_i` high and `call_i` low, on a non-empty stack, removes the top. From the next cycle, `tgt_o` shows the entry that was pushed before it (last in, first out).
- R3: `tgt_valid_o` is 0 exactly when the occupancy is zero. A return on an empty stack leaves the pointer and the occupancy unchanged, so `tgt_o` keeps showing the entry at the pointer.
- R4: The occupancy saturates at DEPTH. A call on a full stack overwrites the oldest slot. After DEPTH+1 calls, DEPTH returns give back the newest DEPTH addresses in reverse order, and the stack is then empty.
- R5: When `call_i` and `ret_i` are high in the same cycle, the return consumes the current top, which is shown on `tgt_o` in that cycle. The new address is written into that same slot and the pointer does not move. The occupancy is unchanged, except that it goes from 0 to 1.
- R6: `ckpt_i` saves the pointer and occupancy that were in force before any push or pop of the same cycle, into the slot selected by `ckpt_tag_i`.
- R7: `rewind_i` reloads the pointer and occupancy from the slot selected by `rewind_tag_i`. A call or return in the same cycle is ignored. A save to the same tag in the same cycle does not affect what is reloaded, which is the value held before that cycle.
- R8: There are 2^TAG_W independent save slots (4 by default), and writing one slot leaves the others intact.
- R9: After reset, the occupancy is 0, the pointer is 0, all entries read 0 and all save slots hold pointer 0 with occupancy 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | A call is being predicted this cycle |
| call_pc_i | input | ADDR_W | Address of that call instruction |
| ret_i | input | 1 | A return is being predicted this cycle |
| ckpt_i | input | 1 | Save the pointer and occupancy |
| ckpt_tag_i | input | TAG_W | Save slot to write |
| rewind_i | input | 1 | Reload the pointer and occupancy |
| rewind_tag_i | input | TAG_W | Save slot to read |
| tgt_o | output | ADDR_W | Predicted return target (entry at the top pointer) |
| tgt_valid_o | output | 1 | High when the occupancy is non-zero |

## Verification
The bench builds the block with DEPTH=6, TAG_W=2 and ADDR_W=32. A depth that is not a power of two makes the pointer wrap through an explicit compare rather than through natural overflow. It also lets random call bursts fill and overrun the stack within a few cycles, so saturation and overwrite occur repeatedly during the random run. Four tags together with frequent saves and reloads produce reloads that coincide with pushes, pops and saves to the same tag.

// File: rtl/retstack_pkg.sv
package retstack_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_PUSH   = 3'd1,
    OP_POP    = 3'd2,
    OP_SWAP   = 3'd3,
    OP_REWIND = 3'd4
  } stack_op_e;

  // next slot up, wrapping at depth
  function automatic int ring_up(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // next slot down, wrapping at depth
  function automatic int ring_down(input int p, input int depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  // occupancy after a push, saturating at depth
  function automatic int fill_up(input int c, input int depth);
    return (c >= depth) ? depth : c + 1;
  endfunction

  // return address of a call
  function automatic logic [63:0] link_addr(input logic [63:0] pc);
    return pc + 64'd4;
  endfunction

endpackage

// File: rtl/retstack_store.sv
module retstack_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [ADDR_W-1:0] rdata
);

  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         slot_q[g] <= '0;
      else if (we && waddr == PW'(g))     slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];

  // a write lands in the addressed slot (R1)
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> slot_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/retstack_ckpt_bank.sv
module retstack_ckpt_bank #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 2,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int NSNAP = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PW-1:0]    wr_ptr,
  input  logic [CW-1:0]    wr_cnt,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [PW-1:0]    rd_ptr,
  output logic [CW-1:0]    rd_cnt
);

  logic [PW-1:0] ptr_q [NSNAP];
  logic [CW-1:0] cnt_q [NSNAP];

  for (genvar g = 0; g < NSNAP; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
        cnt_q[g] <= '0;
      end else if (wr_en && wr_tag == TAG_W'(g)) begin
        ptr_q[g] <= wr_ptr;
        cnt_q[g] <= wr_cnt;
      end
    end

    // untouched slots keep their contents (R8)
    assert_slot_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_tag == TAG_W'(g)) |=> $stable(ptr_q[g]) && $stable(cnt_q[g]));
  end

  assign rd_ptr = ptr_q[rd_tag];
  assign rd_cnt = cnt_q[rd_tag];

endmodule

// File: rtl/retstack_ptr_ctrl.sv
module retstack_ptr_ctrl
  import retstack_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stack_op_e     op,
  input  logic [PW-1:0] load_ptr,
  input  logic [CW-1:0] load_cnt,
  output logic [PW-1:0] tos,
  output logic [CW-1:0] cnt,
  output logic [PW-1:0] push_slot
);

  logic [PW-1:0] tos_d;
  logic [CW-1:0] cnt_d;

  assign push_slot = PW'(ring_up(int'(tos), DEPTH));

  always_comb begin
    tos_d = tos;
    cnt_d = cnt;
    unique case (op)
      OP_PUSH: begin
        tos_d = push_slot;
        cnt_d = CW'(fill_up(int'(cnt), DEPTH));
      end
      OP_POP: begin
        if (cnt != '0) begin
          tos_d = PW'(ring_down(int'(tos), DEPTH));
          cnt_d = cnt - CW'(1);
        end
      end
      OP_SWAP: begin
        if (cnt == '0) cnt_d = CW'(1);
      end
      OP_REWIND: begin
        tos_d = load_ptr;
        cnt_d = load_cnt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos <= '0;
      cnt <= '0;
    end else begin
      tos <= tos_d;
      cnt <= cnt_d;
    end
  end

  assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && cnt < CW'(DEPTH)) |=> cnt == $past(cnt) + CW'(1));

  assert_full_push_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && cnt == CW'(DEPTH)) |=> cnt == CW'(DEPTH));

  assert_empty_pop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && cnt == '0) |=> $stable(tos) && cnt == '0);

  assert_swap_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SWAP |=> $stable(tos) && cnt != '0);

endmodule

// File: rtl/retstack_top.sv
module retstack_top
  import retstack_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 2,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_pc_i,
  input  logic              ret_i,
  input  logic              ckpt_i,
  input  logic [TAG_W-1:0]  ckpt_tag_i,
  input  logic              rewind_i,
  input  logic [TAG_W-1:0]  rewind_tag_i,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              tgt_valid_o
);

  stack_op_e         op;
  logic [PW-1:0]     tos, push_slot, snap_ptr;
  logic [CW-1:0]     cnt, snap_cnt;
  logic              wr_en;
  logic [PW-1:0]     wr_slot;
  logic [ADDR_W-1:0] link;

  always_comb begin
    if (rewind_i)              op = OP_REWIND;
    else if (call_i && ret_i)  op = OP_SWAP;
    else if (call_i)           op = OP_PUSH;
    else if (ret_i)            op = OP_POP;
    else                       op = OP_IDLE;
  end

  assign link    = ADDR_W'(link_addr(64'(call_pc_i)));
  assign wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_slot = (op == OP_SWAP) ? tos : push_slot;

  retstack_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load_ptr (snap_ptr),
    .load_cnt (snap_cnt),
    .tos      (tos),
    .cnt      (cnt),
    .push_slot(push_slot)
  );

  retstack_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .waddr(wr_slot),
    .wdata(link),
    .raddr(tos),
    .rdata(tgt_o)
  );

  retstack_ckpt_bank #(.DEPTH(DEPTH), .TAG_W(TAG_W)) bank_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ckpt_i),
    .wr_tag(ckpt_tag_i),
    .wr_ptr(tos),
    .wr_cnt(cnt),
    .rd_tag(rewind_tag_i),
    .rd_ptr(snap_ptr),
    .rd_cnt(snap_cnt)
  );

  assign tgt_valid_o = (cnt != '0);

  assert_rewind_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_i |=> tos == $past(snap_ptr) && cnt == $past(snap_cnt));

  assert_push_shows_link_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !rewind_i) |=> tgt_o == $past(call_pc_i) + ADDR_W'(4) && tgt_valid_o);

  assert_valid_tracks_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !rewind_i && !tgt_valid_o) |=> !tgt_valid_o);

endmodule

// File: tb/retstack_top_tb_top.sv
module retstack_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int D  = 6;
  localparam int AW = 32;
  localparam int TW = 2;
  localparam int NS = 1 << TW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_i = 1'b0;
  logic [AW-1:0] call_pc_i = '0;
  logic          ret_i = 1'b0;
  logic          ckpt_i = 1'b0;
  logic [TW-1:0] ckpt_tag_i = '0;
  logic          rewind_i = 1'b0;
  logic [TW-1:0] rewind_tag_i = '0;
  logic [AW-1:0] tgt_o;
  logic          tgt_valid_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  logic [AW-1:0] mm [D];
  int mtos, mcnt;
  int stos [NS];
  int scnt [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  retstack_top #(.DEPTH(D), .ADDR_W(AW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc_i(call_pc_i),
    .ret_i(ret_i), .ckpt_i(ckpt_i), .ckpt_tag_i(ckpt_tag_i),
    .rewind_i(rewind_i), .rewind_tag_i(rewind_tag_i),
    .tgt_o(tgt_o), .tgt_valid_o(tgt_valid_o)
  );

  function automatic int wrap(input int v);
    return ((v % D) + D) % D;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < D; i++) mm[i] = '0;
    for (int i = 0; i < NS; i++) begin stos[i] = 0; scnt[i] = 0; end
    mtos = 0; mcnt = 0;
  endtask

  task automatic model_step(input bit c, input logic [AW-1:0] pc, input bit r,
                            input bit k, input int kt, input bit w, input int wt);
    int old_tos = mtos;
    int old_cnt = mcnt;
    int rt = stos[wt];
    int rc = scnt[wt];
    if (w) begin
      mtos = rt; mcnt = rc;
    end else if (c && r) begin
      mm[mtos] = pc + 32'd4;
      if (mcnt == 0) mcnt = 1;
    end else if (c) begin
      mtos = wrap(mtos + 1);
      mm[mtos] = pc + 32'd4;
      if (mcnt < D) mcnt++;
    end else if (r && mcnt > 0) begin
      mtos = wrap(mtos - 1);
      mcnt--;
    end
    if (k) begin stos[kt] = old_tos; scnt[kt] = old_cnt; end
  endtask

  task automatic check_out(input string req);
    vectors++;
    if (tgt_o !== mm[mtos] || tgt_valid_o !== (mcnt != 0)) begin
      errors++;
      $display("FAIL %s: tgt=%h valid=%0b expected tgt=%h valid=%0b",
               req, tgt_o, tgt_valid_o, mm[mtos], (mcnt != 0));
    end
  endtask

  // called at a falling edge; applies one cycle and checks at the next falling edge
  task automatic step(input string req, input bit c, input logic [AW-1:0] pc,
                      input bit r, input bit k = 0, input int kt = 0,
                      input bit w = 0, input int wt = 0);
    call_i = c; call_pc_i = pc; ret_i = r;
    ckpt_i = k; ckpt_tag_i = TW'(kt); rewind_i = w; rewind_tag_i = TW'(wt);
    model_step(c, pc, r, k, kt, w, wt);
    @(posedge clk);
    @(negedge clk);
    check_out(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-1:0] swap_top;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R9 reset state");

    // R1 / R2 basic push and pop
    step("R1 push", 1, 32'h1000, 0);
    step("R1 push", 1, 32'h2000, 0);
    step("R1 push", 1, 32'h3000, 0);
    step("R2 pop", 0, 0, 1);
    step("R2 pop", 0, 0, 1);
    step("R2 pop", 0, 0, 1);
    // R3 pops on empty
    step("R3 empty pop", 0, 0, 1);
    step("R3 empty pop", 0, 0, 1);

    // R4 overflow: D+1 pushes, D pops
    for (int i = 0; i <= D; i++) step("R4 fill", 1, 32'h4000 + 32'(i * 16), 0);
    for (int i = 0; i < D; i++) step("R4 drain", 0, 0, 1);
    step("R4 after drain", 0, 0, 1);

    // R5 simultaneous call and return
    step("R5 setup", 1, 32'h5000, 0);
    step("R5 setup", 1, 32'h5100, 0);
    swap_top = tgt_o;
    vectors++;
    if (swap_top !== 32'h5104) begin
      errors++;
      $display("FAIL R5: top before swap=%h expected %h", swap_top, 32'h5104);
    end
    step("R5 swap", 1, 32'h5200, 1);
    step("R5 pop after swap", 0, 0, 1);
    step("R5 swap on empty", 0, 0, 1);
    step("R5 swap on empty", 1, 32'h5300, 1);

    // R6/R7/R8 save, wrong path, reload
    step("R6 save t1 with push", 1, 32'h6000, 0, 1, 1);
    step("R8 save t2", 1, 32'h6100, 0, 1, 2);
    step("R7 wrong path", 1, 32'h6200, 0);
    step("R7 wrong path", 0, 0, 1);
    step("R7 wrong path", 0, 0, 1);
    step("R7 wrong path", 0, 0, 1);
    step("R7 reload t2 with push ignored", 1, 32'h6300, 0, 0, 0, 1, 2);
    step("R8 reload t1", 0, 0, 1, 0, 0, 1, 1);
    step("R7 reload same tag as save", 1, 32'h6400, 0, 1, 3, 1, 3);
    step("R8 reload t0", 0, 0, 0, 0, 0, 1, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int x = int'($urandom_range(99));
      bit c = (x < 45);
      bit r = (int'($urandom_range(99)) < 40);
      bit k = (int'($urandom_range(99)) < 25);
      bit w = (int'($urandom_range(99)) < 10);
      step("R2 random", c, $urandom & 32'hFFFF_FFFC, r,
           k, int'($urandom_range(NS - 1)), w, int'($urandom_range(NS - 1)));
    end

    call_i = 0; ret_i = 0; ckpt_i = 0; rewind_i = 0;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule